// File: doc/BRIEF.md
# Extended Arithmetic and Logic Unit

This block is the combinational datapath calculator of a small single-cycle processor core. It takes two 32-bit operands and a 4-bit operation code and, within the same cycle, returns a 32-bit result and a flag that is high whenever that result is zero. The core's decoder picks the operation code, and its branch logic reads the flag after a subtract to decide equal or not-equal branches.

The operation set covers modular add and subtract and the four bitwise functions. It also has signed set-on-less-than and logical shifts in both directions. Three operations go beyond the usual set: rotate in either direction, a single-result multiply, and a single-result signed divide. Shift and rotate amounts come from the low five bits of the second operand, because the core shifts register by register and does not use an immediate amount field. The block holds no state and has no clock, so each result depends only on the present inputs.

Top module: `exalu`

## Requirements
- R1: Code 0 returns a + b and code 1 returns a − b, both modulo 2^32.
- R2: Code 2 returns a AND b, code 3 a OR b, code 4 NOT(a OR b), code 5 a XOR b.
- R3: Code 6 shifts a left and code 7 shifts a right, zero-filling, by the amount b[4:0]; bits 31:5 of b have no effect.
- R4: Code 8 rotates a left and code 9 rotates a right by b[4:0]; an amount of 0 returns a unchanged and bits 31:5 of b have no effect.
- R5: Code 10 returns 1 when a is less than b as signed two's-complement values and 0 otherwise; bits 31:1 of the result are always 0.
- R6: Code 11 returns the low 32 bits of the product a × b.
- R7: Code 12 returns the signed quotient a ÷ b truncated toward zero; the case −2^31 ÷ −1 returns 0x80000000.
- R8: Code 12 with b equal to 0 returns 0xFFFFFFFF whatever the value of a.
- R9: The zero flag is 1 exactly when the 32-bit result is 0, for every operation code.
- R10: Codes 13, 14 and 15 return 0 and so raise the zero flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits 4:0 give the shift or rotate amount |
| op_i | input | 4 | Operation code (0 to 12 used) |
| res_o | output | 32 | Result |
| zero_o | output | 1 | High when res_o is zero |

## Verification
The unit holds no state, so any fault shows at the outputs for the same input combination that exposes it, with no latency. A stage of the barrel network tied to the wrong amount bit appears only for amounts that use that bit. A wrong sign or borrow in the divider appears only for operands of particular signs and sizes. For these reasons the sweeps run every shift amount and cross operands of both signs, zero, one, minus one and the extreme values against every operation code. A zero flag that is out of step with the result shows on the first zero result.

// File: rtl/exalu_pkg.sv
package exalu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_NOR = 4'd4,
        OP_XOR = 4'd5,
        OP_SLL = 4'd6,
        OP_SRL = 4'd7,
        OP_ROL = 4'd8,
        OP_ROR = 4'd9,
        OP_SLT = 4'd10,
        OP_MUL = 4'd11,
        OP_DIV = 4'd12
    } exalu_op_e;

endpackage

// File: rtl/exalu_addsub.sv
module exalu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         lt_o
);
    logic [W-1:0] b_eff;
    logic         ovf;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        ovf   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
        // signed less-than: sign of the true difference
        lt_o  = sum_o[W-1] ^ ovf;
    end
endmodule

// File: rtl/exalu_shrot.sv
module exalu_shrot #(
    parameter int W  = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          right_i,
    input  logic          rotate_i,
    output logic [W-1:0]  out_o
);
    logic [W-1:0] stage [0:SW];
    logic [W-1:0] net_out;

    // right-hand operations reuse the left network on a bit-reversed word
    always_comb begin
        for (int i = 0; i < W; i++) begin
            stage[0][i] = right_i ? val_i[W-1-i] : val_i[i];
        end
    end

    for (genvar j = 0; j < SW; j++) begin : g_stage
        localparam int STEP = 1 << j;
        logic [STEP-1:0] low_fill;
        assign low_fill = rotate_i ? stage[j][W-1 -: STEP] : '0;
        assign stage[j+1] = amt_i[j] ? {stage[j][W-1-STEP:0], low_fill} : stage[j];
    end

    assign net_out = stage[SW];

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out_o[i] = right_i ? net_out[W-1-i] : net_out[i];
        end
    end
endmodule

// File: rtl/exalu_muldiv.sv
module exalu_muldiv #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] prod_o,
    output logic [W-1:0] quot_o
);
    logic [W-1:0] num_mag;
    logic [W-1:0] den_mag;
    logic [W-1:0] q_mag;
    logic         q_neg;
    logic         den_zero;

    // low half of a product is the same for signed and unsigned operands
    assign prod_o   = a_i * b_i;

    assign num_mag  = a_i[W-1] ? (~a_i + 1'b1) : a_i;
    assign den_mag  = b_i[W-1] ? (~b_i + 1'b1) : b_i;
    assign q_neg    = a_i[W-1] ^ b_i[W-1];
    assign den_zero = (b_i == '0);

    // unrolled restoring division on magnitudes, one row per quotient bit
    logic [W-1:0] rem_row [0:W-1];
    assign rem_row[0] = '0;

    for (genvar k = 0; k < W; k++) begin : g_row
        localparam int BIT = W - 1 - k;
        logic [W:0] shifted;
        logic [W:0] trial;
        assign shifted    = {rem_row[k], num_mag[BIT]};
        assign trial      = shifted - {1'b0, den_mag};
        assign q_mag[BIT] = ~trial[W];
        if (k < W - 1) begin : g_next
            assign rem_row[k+1] = trial[W] ? shifted[W-1:0] : trial[W-1:0];
        end
    end

    always_comb begin
        if (den_zero) begin
            quot_o = '1;
        end else if (q_neg) begin
            quot_o = ~q_mag + 1'b1;
        end else begin
            quot_o = q_mag;
        end
    end
endmodule

// File: rtl/exalu.sv
module exalu #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]                 a_i,
    input  logic [W-1:0]                 b_i,
    input  logic [exalu_pkg::OP_W-1:0]   op_i,
    output logic [W-1:0]                 res_o,
    output logic                         zero_o
);
    import exalu_pkg::*;

    exalu_op_e    op;
    logic [W-1:0] sum;
    logic         lt;
    logic [W-1:0] shr;
    logic [W-1:0] prod;
    logic [W-1:0] quot;
    logic         is_right;
    logic         is_rot;

    assign op       = exalu_op_e'(op_i);
    assign is_right = (op == OP_SRL) || (op == OP_ROR);
    assign is_rot   = (op == OP_ROL) || (op == OP_ROR);

    exalu_addsub #(.W(W)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (op != OP_ADD),
        .sum_o (sum),
        .lt_o  (lt)
    );

    exalu_shrot #(.W(W)) u_shrot (
        .val_i    (a_i),
        .amt_i    (b_i[SW-1:0]),
        .right_i  (is_right),
        .rotate_i (is_rot),
        .out_o    (shr)
    );

    exalu_muldiv #(.W(W)) u_muldiv (
        .a_i    (a_i),
        .b_i    (b_i),
        .prod_o (prod),
        .quot_o (quot)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB: res_o = sum;
            OP_AND:         res_o = a_i & b_i;
            OP_OR:          res_o = a_i | b_i;
            OP_NOR:         res_o = ~(a_i | b_i);
            OP_XOR:         res_o = a_i ^ b_i;
            OP_SLL, OP_SRL,
            OP_ROL, OP_ROR: res_o = shr;
            OP_SLT:         res_o = {{(W-1){1'b0}}, lt};
            OP_MUL:         res_o = prod;
            OP_DIV:         res_o = quot;
            default:        res_o = '0;
        endcase
    end

    assign zero_o = ~|res_o;
endmodule

// File: rtl/exalu_chk.sv
module exalu_chk #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   op_i,
    input logic [W-1:0] res_o,
    input logic         zero_o
);
    logic [W-1:0] low_mask;
    assign low_mask = (W'(1) << b_i[SW-1:0]) - W'(1);

    always_comb begin
        // R1: subtracting equal operands yields zero and raises the flag
        p_sub_equal_r1: assert (!(op_i == 4'd1 && a_i == b_i) || (res_o == '0 && zero_o))
            else $error("R1 sub of equal operands not zero");
        // R2: AND result is within both operands
        p_and_subset_r2: assert (op_i != 4'd2 || ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0))
            else $error("R2 and result outside operands");
        // R2: NOR result is disjoint from both operands
        p_nor_disjoint_r2: assert (op_i != 4'd4 || (res_o & (a_i | b_i)) == '0)
            else $error("R2 nor result overlaps operands");
        // R3: left shift leaves the vacated low bits clear
        p_sll_fill_r3: assert (op_i != 4'd6 || (res_o & low_mask) == '0)
            else $error("R3 left shift low bits not clear");
        // R4: rotation keeps the population count
        p_rot_pop_r4: assert (!(op_i == 4'd8 || op_i == 4'd9) || $countones(res_o) == $countones(a_i))
            else $error("R4 rotate changed bit count");
        // R5: set-less-than returns only 0 or 1
        p_slt_bit_r5: assert (op_i != 4'd10 || res_o[W-1:1] == '0)
            else $error("R5 slt upper bits set");
        // R6: product of two odd operands is odd
        p_mul_odd_r6: assert (!(op_i == 4'd11 && a_i[0] && b_i[0]) || res_o[0])
            else $error("R6 product parity wrong");
        // R8: division by zero gives all ones
        p_div_zero_r8: assert (!(op_i == 4'd12 && b_i == '0) || res_o == '1)
            else $error("R8 divide by zero not all ones");
        // R9: flag never high with a nonzero result
        p_zero_flag_r9: assert (!zero_o || res_o == '0)
            else $error("R9 zero flag with nonzero result");
        // R10: unused codes give zero
        p_unused_r10: assert (op_i < 4'd13 || (res_o == '0 && zero_o))
            else $error("R10 unused code nonzero");
    end
endmodule

bind exalu exalu_chk #(.W(W)) u_chk (
    .a_i    (a_i),
    .b_i    (b_i),
    .op_i   (op_i),
    .res_o  (res_o),
    .zero_o (zero_o)
);

// File: tb/exalu_tb.sv
`timescale 1ns/1ps
module exalu_tb;
    logic        clk = 1'b0;
    logic [31:0] a, b;
    logic [3:0]  op;
    logic [31:0] res;
    logic        zero;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] pat [16];

    always #4 clk = ~clk;   // 125 MHz

    exalu u_dut (.a_i(a), .b_i(b), .op_i(op), .res_o(res), .zero_o(zero));

    function automatic string req_of(input int code);
        case (code)
            0, 1:          return "R1";
            2, 3, 4, 5:    return "R2";
            6, 7:          return "R3";
            8, 9:          return "R4";
            10:            return "R5";
            11:            return "R6";
            12:            return "R7";
            default:       return "R10";
        endcase
    endfunction

    function automatic logic [31:0] model(input int code, input logic [31:0] x, input logic [31:0] y);
        int s;
        longint px, py;
        s  = int'(y[4:0]);
        px = longint'($signed(x));
        py = longint'($signed(y));
        case (code)
            0:  return x + y;
            1:  return x - y;
            2:  return x & y;
            3:  return x | y;
            4:  return ~(x | y);
            5:  return x ^ y;
            6:  return x << s;
            7:  return x >> s;
            8:  return (s == 0) ? x : ((x << s) | (x >> (32 - s)));
            9:  return (s == 0) ? x : ((x >> s) | (x << (32 - s)));
            10: return (px < py) ? 32'd1 : 32'd0;
            11: return 32'(px * py);
            12: return (y == 0) ? 32'hFFFF_FFFF : 32'(px / py);
            default: return 32'd0;
        endcase
    endfunction

    task automatic apply(input int code, input logic [31:0] x, input logic [31:0] y, input string req);
        logic [31:0] exp;
        @(negedge clk);
        op = 4'(code);
        a  = x;
        b  = y;
        exp = model(code, x, y);
        #1;
        checks++;
        if (res !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, code, x, y, res, exp);
        end
        checks++;
        if (zero !== (exp == 0)) begin   // R9
            errors++;
            $display("FAIL R9 op=%0d a=%h b=%h actual=%b expected=%b", code, x, y, zero, exp == 0);
        end
    endtask

    initial begin
        #(8.0 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        pat[0]  = 32'h0000_0000; pat[1]  = 32'h0000_0001; pat[2]  = 32'hFFFF_FFFF;
        pat[3]  = 32'h8000_0000; pat[4]  = 32'h7FFF_FFFF; pat[5]  = 32'h0000_0007;
        pat[6]  = 32'hFFFF_FFF9; pat[7]  = 32'h1234_5678; pat[8]  = 32'hDEAD_BEEF;
        pat[9]  = 32'h0000_0020; pat[10] = 32'h0000_0003; pat[11] = 32'hFFFF_FFFD;
        pat[12] = 32'hA5A5_A5A5; pat[13] = 32'h0001_0000; pat[14] = 32'hC000_0021;
        pat[15] = 32'h0000_001F;
        op = '0; a = '0; b = '0;

        // idle state: code 0 with zero operands
        #1;
        checks++;
        if (res !== 32'd0 || zero !== 1'b1) begin
            errors++;
            $display("FAIL R9 idle actual=%h/%b expected=00000000/1", res, zero);
        end

        // every code crossed with every operand pattern (R1..R8, R10)
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++)
                    apply(c, pat[i], pat[j], req_of(c));

        // R3, R4: every amount, with junk in b[31:5] that must have no effect
        for (int c = 6; c < 10; c++)
            for (int s = 0; s < 32; s++)
                for (int k = 0; k < 4; k++)
                    apply(c, pat[k + 7], {27'(k * 32'h0BAD_F00D), 5'(s)}, req_of(c));

        // R7: overflow quotient, truncation toward zero
        apply(12, 32'h8000_0000, 32'hFFFF_FFFF, "R7");
        apply(12, 32'hFFFF_FFF9, 32'h0000_0002, "R7");
        apply(12, 32'h0000_0007, 32'hFFFF_FFFE, "R7");
        // R8: divide by zero for several dividends
        apply(12, 32'h8000_0000, 32'h0, "R8");
        apply(12, 32'h0, 32'h0, "R8");
        // R5: signed compare at the extremes
        apply(10, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
        apply(10, 32'h7FFF_FFFF, 32'h8000_0000, "R5");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule